// File: doc/BRIEF.md
# Word-to-Serial Transmit Shifter

This block turns 16-bit parallel words into a continuous serial bit stream. Each cycle of the high-speed serial clock sends one bit. The block divides the serial clock by 16 to make a word-rate clock output. An upstream source uses that clock to present each new word, and the block loads the word on the serial clock edge that ends the divided clock's low phase. Words follow one another with no idle bit between them. A word-valid input marks whether the presented word is real data. When it is low at load time, the block sends an all-zero word instead.

A bit-order input selects least-significant-bit first or most-significant-bit first. The block samples this input when it loads each word, so changing it part-way through a word does not disturb that word. An active-low squelch input forces the serial output to zero. Squelch is ignored while the active-low line-loopback input is asserted. Squelch acts only on the output pin: the shift register and the divider keep running, so bit alignment is unchanged when squelch is released.

Top module: `tx_word_serializer`

## Requirements
- R1: The block samples `word_in` on the rising serial clock edge at which `word_clk` rises. It sends the word's 16 bits over the next 16 serial clock cycles and loads the next word on the edge right after the last bit, so no gap appears between words.
- R2: `word_clk` is the serial clock divided by 16. It is high for 8 cycles and then low for 8 cycles, and it rises in the cycle in which the first bit of a newly loaded word appears on `ser_out`.
- R3: With `msb_first` = 0 at load time, bit 0 of the word is sent first, followed by bits 1, 2 and so on in ascending order up to bit 15.
- R4: With `msb_first` = 1 at load time, bit 15 is sent first, followed by bits 14 down to 0.
- R5: `msb_first` is sampled only at the load edge. Changing it in the middle of a word has no effect on the bits of that word.
- R6: While `squelch_n` = 0 and `loopback_n` = 1, `ser_out` is 0.
- R7: While `loopback_n` = 0, `squelch_n` has no effect and `ser_out` carries the data bit.
- R8: Squelch gates only the output. When squelch is released part-way through a word, `ser_out` resumes with the bit belonging to the current position of that word.
- R9: If `word_valid` = 0 at the load edge, the 16 bits sent for that word slot are all 0.
- R10: During reset, `ser_out` and `word_clk` are 0. The first word is loaded on the first rising edge after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed serial transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_in | input | 16 | Parallel word to transmit |
| word_valid | input | 1 | Marks `word_in` as real data at the load edge |
| msb_first | input | 1 | Bit order: 0 = bit 0 first, 1 = bit 15 first |
| squelch_n | input | 1 | Active-low squelch of the serial output |
| loopback_n | input | 1 | Active-low line-loopback mode; overrides squelch |
| ser_out | output | 1 | Serial data output |
| word_clk | output | 1 | Word-rate clock, serial clock divided by 16 |

## Verification
The embedded assertions run on every cycle. They check that `word_clk` changes level only at the start of a word and at its midpoint. They also check that a valid word is captured whole at the load edge and that an idle slot captures zeros. Finally, they check that an unforced squelch drives the output low and that the output stays at zero before the first valid word. The actual bit sequence can only be shown by the bench scenarios: which bit goes out in which cycle under each order setting, that order changes made mid-word have no effect, that loopback overrides squelch, and that the correct bit position resumes after a squelch is released mid-word.

// File: rtl/tx_word_serializer.sv
module tx_word_serializer #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic              word_valid,
  input  logic              msb_first,
  input  logic              squelch_n,
  input  logic              loopback_n,
  output logic              ser_out,
  output logic              word_clk
);

  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);
  localparam logic [CW-1:0] HALF = CW'(WORD_W / 2);

  logic [CW-1:0]     cnt, cnt_nxt;
  logic [WORD_W-1:0] sreg;
  logic              order_q;
  logic              started;
  logic              wclk_q;
  logic              load;
  logic              data_bit;
  logic              mute;

  assign load     = (cnt == LAST);
  assign cnt_nxt  = load ? '0 : CW'(cnt + 1'b1);
  assign data_bit = order_q ? sreg[WORD_W-1] : sreg[0];
  assign mute     = ~squelch_n & loopback_n;
  assign ser_out  = data_bit & ~mute;
  assign word_clk = wclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= LAST;
      wclk_q  <= 1'b0;
      sreg    <= '0;
      order_q <= 1'b0;
      started <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      wclk_q <= (cnt_nxt < HALF);
      if (load) begin
        sreg    <= word_valid ? word_in : '0;
        order_q <= msb_first;
        started <= started | word_valid;
      end else if (order_q) begin
        sreg <= {sreg[WORD_W-2:0], 1'b0};
      end else begin
        sreg <= {1'b0, sreg[WORD_W-1:1]};
      end
    end
  end

  // R2: level changes only at word start or midpoint
  a_r2_clk_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (wclk_q != $past(wclk_q)) |-> (cnt == '0 || cnt == HALF));

  // R2: a rising word clock stays high on the next cycle
  a_r2_duty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wclk_q) |=> wclk_q);

  // R1: a valid word is captured whole at load
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (load && word_valid) |=> (sreg == $past(word_in)));

  // R9: an idle slot loads zeros
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !word_valid) |=> (sreg == '0));

  // R6: squelch outside loopback forces zero
  a_r6_squelch: assert property (@(posedge clk) disable iff (!rst_n)
    (!squelch_n && loopback_n) |-> !ser_out);

  // R10: nothing is sent before the first valid word
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !ser_out);

endmodule

// File: tb/tx_word_serializer_bench.sv
module tx_word_serializer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] word_in = '0;
  logic        word_valid = 1'b0;
  logic        msb_first = 1'b0;
  logic        squelch_n = 1'b1;
  logic        loopback_n = 1'b1;
  logic        ser_out;
  logic        word_clk;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  tx_word_serializer u_tx_word_serializer (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .word_valid(word_valid),
    .msb_first(msb_first), .squelch_n(squelch_n), .loopback_n(loopback_n),
    .ser_out(ser_out), .word_clk(word_clk)
  );

  function automatic logic exp_bit(input logic [15:0] w, input logic ord, input int i);
    return ord ? w[15 - i] : w[i];
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // sq_mode: 0 never squelch, 1 always, 2 random per bit, 3 squelch first half only
  task automatic run_word(input logic [15:0] w, input logic v, input logic ord,
                          input logic lb_n, input int sq_mode, input logic flip,
                          input string req);
    logic sq;
    logic exp;
    word_in    = w;
    word_valid = v;
    msb_first  = ord;
    loopback_n = lb_n;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      case (sq_mode)
        0: squelch_n = 1'b1;
        1: squelch_n = 1'b0;
        2: squelch_n = 1'($urandom_range(0, 1));
        default: squelch_n = (i >= 8);
      endcase
      if (flip && i == 5) msb_first = ~ord;
      #1;
      sq  = !squelch_n && lb_n;
      exp = sq ? 1'b0 : (v ? exp_bit(w, ord, i) : 1'b0);
      chk(ser_out, exp, req);
      chk(word_clk, (i < 8), "R2");
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    #1;
    chk(ser_out, 1'b0, "R10");
    chk(word_clk, 1'b0, "R10");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    run_word(16'hA5C3, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R10");
    run_word(16'h0001, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R3");
    run_word(16'h0001, 1'b1, 1'b1, 1'b1, 0, 1'b0, "R4");
    run_word(16'h8000, 1'b1, 1'b1, 1'b1, 0, 1'b0, "R4");
    run_word(16'h1234, 1'b1, 1'b0, 1'b1, 0, 1'b1, "R5");
    run_word(16'h1234, 1'b1, 1'b1, 1'b1, 0, 1'b1, "R5");
    run_word(16'hFFFF, 1'b1, 1'b0, 1'b1, 1, 1'b0, "R6");
    run_word(16'hFFFF, 1'b1, 1'b1, 1'b0, 1, 1'b0, "R7");
    run_word(16'hF0F0, 1'b1, 1'b0, 1'b1, 3, 1'b0, "R8");
    run_word(16'hFFFF, 1'b0, 1'b0, 1'b1, 0, 1'b0, "R9");
    run_word(16'hBEEF, 1'b1, 1'b1, 1'b1, 0, 1'b0, "R1");
    for (int n = 0; n < 200; n++) begin
      run_word(16'($urandom), ($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
               1'($urandom_range(0, 1)), "R1");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule